// File: doc/BRIEF.md
# Width-Selectable Compare Flag Generator

This block turns the outcome of a compare into a condition-code word that can be written into a general register. It takes the two compare operands, the result that the ALU produced from them, the ALU opcode and a 2-bit width code. From these it works out zero, sign, signed overflow and carry at 8, 16 or 32 bits. It then derives the unsigned "above" relation and the signed "greater" and "greater-or-equal" relations and packs all seven flags into the low bits of a 32-bit word.

The logic is purely combinational and holds no state. Only the bits of the operands and of the result that lie inside the selected width affect the flags. Carry comes from a masked add or subtract that the block recomputes itself, and it is defined only when the opcode is add or subtract.

Top module: `cmp_flag_gen`

## Requirements
- R1: Width code 0 compares 8 bits (sign position 7), code 1 compares 16 bits (sign position 15), and code 2 compares 32 bits (sign position 31).
- R2: Width code 3 behaves exactly like width code 2.
- R3: Zero (bit 0) is 1 exactly when the result, masked to the selected width, is all zeros.
- R4: Sign (bit 3) equals the result bit at the selected sign position.
- R5: Overflow (bit 2) is 1 when the result sign differs from A's bit at the sign position and A's and B's bits at the sign position differ.
- R6: For opcode 0 (add), carry (bit 1) is the bit just above the width of masked A plus masked B. For opcode 2 (subtract), it is the same bit of masked A minus masked B, taken in at least width+1 bits.
- R7: For every opcode other than 0 and 2, carry is 0.
- R8: Above (bit 6) is 1 exactly when carry and zero are both 0.
- R9: Greater-or-equal (bit 4) is 1 when sign equals overflow; greater (bit 5) is greater-or-equal with zero clear.
- R10: The output bits from 6 down to 0 are above, greater, greater-or-equal, sign, overflow, carry, zero, and bits 31:7 are always 0.
- R11: Bits of A, B and the result above the selected width have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First compare operand |
| opb | input | 32 | Second compare operand |
| alu_res | input | 32 | ALU result computed from opa and opb |
| alu_op | input | 4 | ALU opcode: 0 add, 2 subtract, others logic or shift |
| width_sel | input | 2 | Compare width: 0 byte, 1 halfword, 2 or 3 word |
| flags_o | output | 32 | Packed condition-code word |

## Verification
The bench fills the bits above a narrow width with junk. A design that forgot to mask would then clear zero, set carry wrongly, or take sign from the wrong bit. It drives a word-size subtract that crosses the signed limit, so swapped overflow terms or an inverted greater relation show up as a wrong code. It uses an add whose carry leaves exactly bit 32 and runs a logic opcode whose masked operands would otherwise produce a carry, which catches a carry that is too narrow or not gated by the opcode. Width code 3 is compared against code 2, and a long pseudo-random sweep over all widths and several opcodes catches packing or bit-order slips.

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [OP_W-1:0]   alu_op,
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] flags_o
);

  localparam int NFLAGS = 7;
  localparam logic [OP_W-1:0] OP_ADD = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB = OP_W'(2);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] msb_mask;
  logic [DATA_W:0]   carry_mask;
  logic [DATA_W:0]   ext_a, ext_b, arith;
  logic is_add, is_sub;
  logic f_zero, f_sign, f_ovf, f_carry, f_above, f_gt, f_ge;
  logic a_hi, b_hi;

  always_comb begin
    case (width_sel)
      2'd0:    mask = DATA_W'(8'hFF);
      2'd1:    mask = DATA_W'(16'hFFFF);
      default: mask = '1;
    endcase
  end

  assign msb_mask   = mask ^ (mask >> 1);
  assign carry_mask = {1'b0, mask} + 1'b1;

  assign is_add = (alu_op == OP_ADD);
  assign is_sub = (alu_op == OP_SUB);
  assign ext_a  = {1'b0, opa & mask};
  assign ext_b  = {1'b0, opb & mask};
  assign arith  = is_sub ? (ext_a - ext_b) : (ext_a + ext_b);

  assign f_zero  = ((alu_res & mask) == '0);
  assign f_sign  = |(alu_res & msb_mask);
  assign a_hi    = |(opa & msb_mask);
  assign b_hi    = |(opb & msb_mask);
  assign f_ovf   = (f_sign != a_hi) && (a_hi != b_hi);
  assign f_carry = (is_add || is_sub) && (|(arith & carry_mask));
  assign f_above = !f_carry && !f_zero;
  assign f_ge    = (f_sign == f_ovf);
  assign f_gt    = f_ge && !f_zero;

  assign flags_o = {{(DATA_W-NFLAGS){1'b0}},
                    f_above, f_gt, f_ge, f_sign, f_ovf, f_carry, f_zero};

  always_comb begin
    AST_ABOVE_EXCLUDES_ZERO: assert (!(flags_o[6] && flags_o[0])) else $error("above with zero"); // R8
    AST_GT_IMPLIES_GE: assert (!flags_o[5] || flags_o[4]) else $error("greater without ge"); // R9
    AST_ZERO_CLEARS_SIGN: assert (!flags_o[0] || !flags_o[3]) else $error("zero with sign"); // R3
    AST_CARRY_ONLY_ADDSUB: assert (!flags_o[1] || alu_op == OP_ADD || alu_op == OP_SUB) else $error("carry on other op"); // R7
  end

endmodule

// File: tb/tb_cmp_flag_gen.sv
module tb_cmp_flag_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opa, opb, alu_res, flags_o;
  logic [3:0]  alu_op;
  logic [1:0]  width_sel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cmp_flag_gen dut (
    .opa(opa), .opb(opb), .alu_res(alu_res),
    .alu_op(alu_op), .width_sel(width_sel), .flags_o(flags_o)
  );

  function automatic logic [31:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] r, input logic [3:0] op,
                                            input logic [1:0] w);
    int n;
    logic [63:0] ma, mb, mr, t;
    logic z, s, ah, bh, v, c;
    n  = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    ma = {32'd0, a} & ((64'd1 << n) - 1);
    mb = {32'd0, b} & ((64'd1 << n) - 1);
    mr = {32'd0, r} & ((64'd1 << n) - 1);
    z  = (mr == 0);
    s  = mr[n-1];
    ah = ma[n-1];
    bh = mb[n-1];
    v  = (s != ah) && (ah != bh);
    if (op == 4'd0)      begin t = ma + mb; c = t[n]; end
    else if (op == 4'd2) begin t = ma - mb; c = t[n]; end
    else c = 1'b0;
    return {25'd0, (!c && !z), ((s == v) && !z), (s == v), s, v, c, z};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] r,
                       input logic [3:0] op, input logic [1:0] w);
    @(negedge clk);
    opa = a; opb = b; alu_res = r; alu_op = op; width_sel = w;
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (flags_o !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, flags_o, exp);
    end
  endtask

  task automatic t_idle;
    apply(0, 0, 0, 4'd0, 2'd0);
    check("R10 idle inputs", 32'h11);
  endtask

  task automatic t_byte_sub_borrow;
    apply(32'h05, 32'h07, 32'hFE, 4'd2, 2'd0);
    check("R6 R4 byte subtract borrow", 32'h0A);
  endtask

  task automatic t_byte_add_junk;
    apply(32'hFFFFFF80, 32'h12345680, 32'hABCDEF00, 4'd0, 2'd0);
    check("R11 R3 R1 byte add with upper junk", 32'h13);
  endtask

  task automatic t_word_ovf;
    apply(32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'd2, 2'd2);
    check("R5 R9 word signed overflow", 32'h3E);
  endtask

  task automatic t_size3;
    apply(32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'd2, 2'd3);
    check("R2 width code 3 as word", 32'h3E);
  endtask

  task automatic t_half_above;
    apply(32'hFFFF0009, 32'h00AA0003, 32'h77770006, 4'd2, 2'd1);
    check("R8 R9 halfword above and greater", 32'h70);
  endtask

  task automatic t_logic_no_carry;
    apply(32'hFF, 32'hFF, 32'hFF, 4'd4, 2'd0);
    check("R7 logic opcode has no carry", 32'h48);
  endtask

  task automatic t_word_add_carry;
    apply(32'hFFFFFFFF, 32'h1, 32'h0, 4'd0, 2'd2);
    check("R6 R5 word add carry out", 32'h07);
  endtask

  task automatic t_half_sign;
    apply(32'h0, 32'h0, 32'h00018000, 4'd5, 2'd1);
    check("R4 R1 halfword sign position", 32'h48);
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, r;
      logic [3:0] op;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf * 32'h9E3779B1;
      b = lf ^ 32'h5A5A1234;
      op = (i % 3 == 0) ? 4'd0 : (i % 3 == 1) ? 4'd2 : 4'(i % 16);
      r = (op == 4'd0) ? a + b : (op == 4'd2) ? a - b : a & b;
      if (i % 7 == 0) r = r & 32'hFFFF0000;
      apply(a, b, r, op, 2'(i));
      check("R10 sweep", ref_flags(a, b, r, op, 2'(i)));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    opa = 0; opb = 0; alu_res = 0; alu_op = 0; width_sel = 0;
    t_idle();
    t_byte_sub_borrow();
    t_byte_add_junk();
    t_word_ovf();
    t_size3();
    t_half_above();
    t_logic_no_carry();
    t_word_add_carry();
    t_half_sign();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule